// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the data-path core of a small accumulator machine. Each cycle it may be handed the current accumulator value, a second operand (taken by surrounding logic from a scratchpad register, a memory byte or an immediate field) and a 4-bit operation code. It returns the new accumulator value combinationally, together with a write strobe for the accumulator, and it keeps four status bits (carry, zero, sign, overflow) in its own register, which loads on the clock edge of any operation that affects them.

The operation set covers binary and decimal (BCD) addition, bitwise AND, OR and XOR, a compare that only touches the flags, one-bit and four-bit shifts in both directions, complement, add-carry, increment, clear, a short load that fills only the low nibble, and a plain load of the operand. The sign bit follows an inverted convention: it is set when the result's top bit is clear, so it reads as "non-negative". Fetch, decode, operand selection and memory access belong to the surrounding machine.

Top module: `acc_alu`

## Requirements
- R1: For every operation that updates the flags, zero is 1 exactly when the 8-bit result is 0x00 and sign is the inverse of result bit 7, except where R4 forces sign.
- R2: Codes 2 (AND), 3 (OR), 4 (XOR) give accumulator op operand, code 10 gives the bitwise complement of the accumulator; all four clear carry and overflow.
- R3: Code 0 adds accumulator and operand, code 12 adds one to the accumulator; carry is the carry out of bit 7 and overflow is 1 when the two addends share bit 7 and the result's bit 7 differs from it (for increment the second addend is 0x00 and the one enters as carry-in).
- R4: Codes 6 and 7 shift the accumulator right by one and by four, filling with zeros; carry and overflow are cleared and sign is forced to 1.
- R5: Codes 8 and 9 shift the accumulator left by one and by four, filling with zeros; carry and overflow are cleared.
- R6: Code 5 forms operand + ~accumulator + 1 (operand minus accumulator); the flags take carry, zero, sign and overflow of that sum as in R1 and R3 with addends operand and ~accumulator, the write strobe stays low and the result output equals the accumulator input.
- R7: Code 1 adds the two operands as two BCD digits: each 4-bit digit sum (with the carry from the digit below) that exceeds 9 has 6 added and passes a carry to the next digit; carry is the carry out of the high digit and overflow follows the R3 rule on accumulator, operand and corrected result.
- R8: Code 11 adds the registered carry flag to the accumulator, with carry and overflow as in R3 (second addend 0x00).
- R9: Code 13 yields 0x00, code 14 yields {4'h0, operand[3:0]}, code 15 yields the operand; all three assert the write strobe and leave the flag register unchanged.
- R10: The write strobe is high only when op_valid is high and the code is not 5; while op_valid is low the flags hold.
- R11: While reset is active all four flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation select (codes in R2 to R9) |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand |
| result | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag (1 when non-negative) |
| flag_o | output | 1 | Registered overflow flag |

## Verification
The result path is combinational, so a wrong adder, decimal correction or shift shows on result in the same cycle the operands are presented. The only stored state is the flag register: a wrong flag appears on the flag outputs one edge after the operation, and a wrong carry flag also corrupts the very next add-carry result, which the bench follows by chaining operations against its own flag model. A flag register that loads when it should hold shows up after loads, clears and idle cycles, which the bench interleaves with flag-setting operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_DADD = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_SHR1 = 4'd6,
    OP_SHR4 = 4'd7,
    OP_SHL1 = 4'd8,
    OP_SHL4 = 4'd9,
    OP_COM  = 4'd10,
    OP_LNK  = 4'd11,
    OP_INC  = 4'd12,
    OP_CLR  = 4'd13,
    OP_LDS  = 4'd14,
    OP_LD   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_bin_add.sv
module acc_alu_bin_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/acc_alu_dec_add.sv
module acc_alu_dec_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int DIGITS = W / 4;

  logic [DIGITS:0] cy;
  assign cy[0] = 1'b0;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [4:0] raw;
    logic       fix;
    always_comb begin
      raw = {1'b0, a[4*d +: 4]} + {1'b0, b[4*d +: 4]} + {4'b0, cy[d]};
      fix = (raw > 5'd9);
    end
    assign sum[4*d +: 4] = raw[3:0] + (fix ? 4'd6 : 4'd0);
    assign cy[d+1]       = fix;
  end

  assign cout = cy[DIGITS];
endmodule

// File: rtl/acc_alu_logic_unit.sv
module acc_alu_logic_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int NIB = 4;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_SHR1: res = a >> 1;
      OP_SHR4: res = a >> NIB;
      OP_SHL1: res = a << 1;
      OP_SHL4: res = a << NIB;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_flag_reg.sv
module acc_alu_flag_reg
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  alu_flags_t d,
  output alu_flags_t q
);
  alu_flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  output logic [W-1:0] result,
  output logic         acc_we,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_o
);
  localparam int NIB = 4;

  // reset: asserts at once, releases after two clock edges
  logic [1:0] rst_q;
  logic       rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_sync = rst_q[1];

  alu_op_e    op;
  alu_flags_t flags_q;
  alu_flags_t flags_d;
  logic       flags_ld;

  assign op = alu_op_e'(op_code);

  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_cout, add_ovf;
  logic [W-1:0] dec_sum, lu_res;
  logic         dec_cout, dec_ovf;

  always_comb begin
    add_a   = acc_in;
    add_b   = opnd_in;
    add_cin = 1'b0;
    unique case (op)
      OP_CMP: begin add_a = opnd_in; add_b = ~acc_in; add_cin = 1'b1; end
      OP_LNK: begin add_b = '0; add_cin = flags_q.c; end
      OP_INC: begin add_b = '0; add_cin = 1'b1; end
      default: ;
    endcase
  end

  acc_alu_bin_add #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  acc_alu_dec_add #(.W(W)) u_dec (
    .a(acc_in), .b(opnd_in), .sum(dec_sum), .cout(dec_cout)
  );

  assign dec_ovf = (acc_in[W-1] == opnd_in[W-1]) && (dec_sum[W-1] != acc_in[W-1]);

  acc_alu_logic_unit #(.W(W)) u_lu (
    .op(op), .a(acc_in), .b(opnd_in), .res(lu_res)
  );

  logic [W-1:0] flag_src;

  always_comb begin
    result   = acc_in;
    flag_src = acc_in;
    flags_d  = flags_q;
    flags_ld = 1'b0;
    unique case (op)
      OP_ADD, OP_LNK, OP_INC, OP_CMP: begin
        flag_src  = add_sum;
        result    = (op == OP_CMP) ? acc_in : add_sum;
        flags_d.c = add_cout;
        flags_d.o = add_ovf;
        flags_ld  = 1'b1;
      end
      OP_DADD: begin
        flag_src  = dec_sum;
        result    = dec_sum;
        flags_d.c = dec_cout;
        flags_d.o = dec_ovf;
        flags_ld  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_COM,
      OP_SHR1, OP_SHR4, OP_SHL1, OP_SHL4: begin
        flag_src  = lu_res;
        result    = lu_res;
        flags_d.c = 1'b0;
        flags_d.o = 1'b0;
        flags_ld  = 1'b1;
      end
      OP_CLR: result = '0;
      OP_LDS: result = {{(W-NIB){1'b0}}, opnd_in[NIB-1:0]};
      OP_LD:  result = opnd_in;
      default: ;
    endcase
    flags_d.z = (flag_src == '0);
    flags_d.s = (op == OP_SHR1 || op == OP_SHR4) ? 1'b1 : ~flag_src[W-1];
    if (!flags_ld) flags_d = flags_q;
  end

  assign acc_we = op_valid && (op != OP_CMP);

  acc_alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n_sync), .load_en(op_valid && flags_ld),
    .d(flags_d), .q(flags_q)
  );

  assign flag_c = flags_q.c;
  assign flag_z = flags_q.z;
  assign flag_s = flags_q.s;
  assign flag_o = flags_q.o;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] result,
  input logic         acc_we,
  input logic         flag_c,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_o
);
  logic is_logic, is_shr, is_load;
  assign is_logic = op_code inside {4'd2, 4'd3, 4'd4, 4'd10};
  assign is_shr   = op_code inside {4'd6, 4'd7};
  assign is_load  = op_code inside {4'd13, 4'd14, 4'd15};

  assert_zero_means_sign_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    flag_z |-> flag_s);

  assert_logic_clears_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && is_logic) |=> (!flag_c && !flag_o));

  assert_shr_sign_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && is_shr) |=> (flag_s && !flag_c && !flag_o));

  assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == 4'd5) |-> (!acc_we && result == acc_in));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == 4'd13) |-> (acc_we && result == '0));

  assert_load_holds_flags_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && is_load) |=> ($stable(flag_c) && $stable(flag_z) && $stable(flag_s) && $stable(flag_o)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> ($stable(flag_c) && $stable(flag_z) && $stable(flag_s) && $stable(flag_o)));

  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |-> !acc_we);
endmodule

bind acc_alu acc_alu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_ok(rst_n_sync), .op_valid(op_valid), .op_code(op_code),
  .acc_in(acc_in), .result(result), .acc_we(acc_we),
  .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] acc_in, opnd_in;
  logic [7:0] result;
  logic       acc_we, flag_c, flag_z, flag_s, flag_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [3:0] mflags;  // model {c,z,s,o}

  always #2 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .result(result), .acc_we(acc_we),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd12:               return "R3";
      4'd1:                      return "R7";
      4'd2, 4'd3, 4'd4, 4'd10:   return "R2";
      4'd5:                      return "R6";
      4'd6, 4'd7:                return "R4";
      4'd8, 4'd9:                return "R5";
      4'd11:                     return "R8";
      default:                   return "R9";
    endcase
  endfunction

  // returns {upd, we, c, z, s, o, res[7:0]}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic cf);
    logic [8:0] w; logic [7:0] r, x, y; logic c, o, upd, s;
    int lo, hi, lc;
    upd = 1'b1; c = 1'b0; o = 1'b0; r = a; x = a; y = b;
    case (op)
      4'd0:  begin x = a; y = b; w = a + b; end
      4'd12: begin x = a; y = 8'h00; w = a + 1; end
      4'd11: begin x = a; y = 8'h00; w = a + cf; end
      4'd5:  begin x = b; y = ~a; w = b + {1'b0, ~a} + 1; end
      default: w = '0;
    endcase
    case (op)
      4'd0, 4'd12, 4'd11, 4'd5: begin
        r = w[7:0]; c = w[8]; o = (x[7] == y[7]) && (r[7] != x[7]);
      end
      4'd1: begin
        lo = a[3:0] + b[3:0]; lc = (lo > 9) ? 1 : 0; if (lo > 9) lo += 6;
        hi = a[7:4] + b[7:4] + lc; c = (hi > 9); if (hi > 9) hi += 6;
        r = {hi[3:0], lo[3:0]}; o = (a[7] == b[7]) && (r[7] != a[7]);
      end
      4'd2:  r = a & b;
      4'd3:  r = a | b;
      4'd4:  r = a ^ b;
      4'd10: r = ~a;
      4'd6:  r = {1'b0, a[7:1]};
      4'd7:  r = {4'h0, a[7:4]};
      4'd8:  r = {a[6:0], 1'b0};
      4'd9:  r = {a[3:0], 4'h0};
      4'd13: begin r = 8'h00; upd = 1'b0; end
      4'd14: begin r = {4'h0, b[3:0]}; upd = 1'b0; end
      default: begin r = b; upd = 1'b0; end
    endcase
    s = (op == 4'd6 || op == 4'd7) ? 1'b1 : ~r[7];
    if (op == 4'd5) return {upd, 1'b0, c, (r == 8'h00), s, o, a};
    return {upd, 1'b1, c, (r == 8'h00), s, o, r};
  endfunction

  task automatic do_op(input logic v, input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [13:0] m; string t;
    @(negedge clk);
    op_valid = v; op_code = op; acc_in = a; opnd_in = b;
    m = model(op, a, b, mflags[3]);
    t = v ? tag_of(op) : "R10";
    #1;
    if (v) begin
      check(result == m[7:0], t, {8'h0, result}, {8'h0, m[7:0]});
      check(acc_we == m[12], t, {15'h0, acc_we}, {15'h0, m[12]});
      if (m[13]) mflags = m[11:8];
    end else begin
      check(acc_we == 1'b0, "R10", {15'h0, acc_we}, 16'h0);
    end
    @(posedge clk); #1;
    check({flag_c, flag_z, flag_s, flag_o} == mflags, t,
          {12'h0, flag_c, flag_z, flag_s, flag_o}, {12'h0, mflags});
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; acc_in = 8'h00; opnd_in = 8'h00;
    mflags = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    check({flag_c, flag_z, flag_s, flag_o} == 4'b0000, "R11",
          {12'h0, flag_c, flag_z, flag_s, flag_o}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // directed corners
    do_op(1, 4'd0, 8'h7F, 8'h01);  // R3 signed overflow
    do_op(1, 4'd0, 8'hFF, 8'h01);  // R3 carry, zero -> R1 sign set
    do_op(1, 4'd11, 8'h10, 8'h00); // R8 uses carry=1
    do_op(1, 4'd11, 8'h10, 8'h00); // R8 carry now 0
    do_op(1, 4'd12, 8'h7F, 8'h00); // R3 increment overflow
    do_op(1, 4'd1, 8'h19, 8'h28);  // R7 -> 0x47
    do_op(1, 4'd1, 8'h99, 8'h01);  // R7 -> 0x00 carry
    do_op(1, 4'd5, 8'h05, 8'h05);  // R6 equal
    do_op(1, 4'd5, 8'h06, 8'h05);  // R6 borrow
    do_op(1, 4'd6, 8'h80, 8'h00);  // R4
    do_op(1, 4'd7, 8'hF0, 8'h00);  // R4
    do_op(1, 4'd9, 8'h1F, 8'h00);  // R5 -> F0 sign 0
    do_op(1, 4'd0, 8'hFF, 8'h01);  // set carry
    do_op(1, 4'd13, 8'h55, 8'h00); // R9 clear keeps flags
    do_op(1, 4'd14, 8'h55, 8'hAB); // R9 short load
    do_op(1, 4'd15, 8'h55, 8'h80); // R9 load
    do_op(0, 4'd0, 8'h01, 8'h01);  // R10 idle
    do_op(1, 4'd10, 8'hFF, 8'h00); // R2 complement -> zero
    do_op(1, 4'd2, 8'hF0, 8'h0F);  // R2 AND zero
    do_op(1, 4'd8, 8'hC0, 8'h00);  // R5 shl1

    for (int i = 0; i < 4000; i++) begin
      logic v; logic [3:0] op; logic [7:0] a, b;
      v  = ($urandom_range(0, 7) != 0);
      op = 4'($urandom_range(0, 15));
      a  = 8'($urandom());
      b  = 8'($urandom());
      if (op == 4'd1) begin  // keep BCD digits valid
        a = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        b = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      end
      do_op(v, op, a, b);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule